// File: doc/BRIEF.md
# Twin-Predicated Element Loop Sequencer

This block is a hardware element loop that sits between instruction issue and decode. When a vectorised instruction is started, it holds the program counter and walks two step counters, one for source elements and one for destination elements. Each counter has its own predicate mask. An element operation is issued only when both current mask bits are live. A dead source bit advances only the source step, and a dead destination bit advances only the destination step. Using one mask alone gives compress-style or expand-style movement, and using a mask against its own complement interleaves the elements.

The step counters are architectural state. They can be written while the loop is idle, and a later start resumes from the values written, for example after an interrupt. Two further options change how the loop runs. Data-dependent fail-first ends the loop on the first element the downstream test reports as failing, and shortens the vector length to that destination position, with or without the failing element. Vertical-first mode issues a single element per instruction and moves the steps forward only on an explicit step command. With a length of one and no options set, the block behaves like one scalar operation.

Top module: `elem_loop_seq`

## Requirements
- R1: After reset the loop is idle (`busy` low), both steps read 0, `vl_cur` reads 0, and `el_valid` and `done` are low.
- R2: A `start` accepted while idle sets `busy` from the next cycle until the instruction finishes, so the program counter stays held. `done` is a one-cycle pulse in the last cycle of the instruction, and `busy` is low in the cycle after it. `start` is ignored while `busy` is high.
- R3: Element pairs are issued with source and destination indices in ascending order. A pair is issued only when both current bits are live, and both steps then advance by one. A dead source bit advances only the source step, and a dead destination bit advances only the destination step.
- R4: Bit i of the source mask governs source element i, and bit i of the destination mask governs destination element i. An invert flag complements a lane's mask. A lane whose enable is low treats every element as live. Example: source mask 0b0101 with destination mask 0b0101 inverted, at VL 4, gives the pairs (0,1) and (2,3).
- R5: The loop ends in the first cycle in which either step is at or above VL. In that cycle `done` pulses, no pair is issued, and both steps return to 0. With VL 0 nothing is issued.
- R6: Issue uses a valid/ready handshake with at most one pair per cycle. While `el_ready` is low, `el_valid`, `el_src` and `el_dst` hold steady.
- R7: A state write (`st_wr`) while idle loads both steps, and the next start resumes from those values. A state write while busy is ignored.
- R8: With fail-first enabled, an accepted pair that has `el_fail` high ends the loop. `vl_cur` becomes the destination index, or that index plus one when the include flag is set. `vl_cut` pulses and both steps return to 0. With fail-first disabled, `el_fail` has no effect.
- R9: In vertical-first mode the block issues one pair, then goes idle with the steps left unchanged. A `vf_step` while idle advances both steps by one, and both steps return to 0 when either would reach `vl_cur`.
- R10: VL 1 with all options off issues exactly the pair (0,0), then `done` follows, leaving the steps at 0.
- R11: VL is accepted up to MAX_VL (128 by default). A larger requested value is clamped to MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one vectorised instruction (idle only) |
| cfg_vl | input | LW | Requested vector length |
| cfg_src_mask | input | MAX_VL | Source predicate mask |
| cfg_dst_mask | input | MAX_VL | Destination predicate mask |
| cfg_src_en | input | 1 | Source predication enable |
| cfg_dst_en | input | 1 | Destination predication enable |
| cfg_src_inv | input | 1 | Invert source mask |
| cfg_dst_inv | input | 1 | Invert destination mask |
| cfg_vf | input | 1 | Vertical-first mode |
| cfg_ff | input | 1 | Data-dependent fail-first enable |
| cfg_ff_incl | input | 1 | Count the failing element in the new VL |
| st_wr | input | 1 | Write both steps (idle only) |
| st_src | input | LW | Source step value to write |
| st_dst | input | LW | Destination step value to write |
| vf_step | input | 1 | Explicit vertical-first step command |
| el_valid | output | 1 | Element pair offered |
| el_ready | input | 1 | Downstream accepts the pair |
| el_src | output | IW | Source element index |
| el_dst | output | IW | Destination element index |
| el_fail | input | 1 | Condition test failed for the accepted pair |
| busy | output | 1 | Loop running, program counter held |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| src_step | output | LW | Current source step |
| dst_step | output | LW | Current destination step |
| vl_cur | output | LW | Current vector length |
| vl_cut | output | 1 | VL truncated by fail-first |

## Verification
The sequence of pairs is compared with a step-walking model under several mask patterns:
- both lanes unpredicated, which shows the plain count;
- one lane masked, which shows compress against expand;
- complementary masks, which shows the interleaved pairing;
- dense random masks with inversion, which shows that each counter skips on its own.

Preloaded nonzero steps show that a resumed loop continues exactly where it stopped. Fail-first runs place the failure at chosen ordinals to separate the include and exclude lengths, and repeat the same failure with the option off, where it must have no effect. Ready is throttled at random to stress the handshake. Vertical-first single steps and wrap-around, VL 0, VL 1 and VL above the maximum cover the edges.

// File: rtl/eseq_pkg.sv
package eseq_pkg;

  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_t;

  typedef struct packed {
    logic vf;
    logic ff;
    logic incl;
  } mode_t;

  // A lane element is live when predication is off, or when its mask bit
  // (after optional inversion) is one.
  function automatic logic lane_live(input logic bit_in, input logic en,
                                     input logic inv);
    return !en || (bit_in ^ inv);
  endfunction

  // New vector length after a fail-first hit at destination position pos.
  function automatic int unsigned cut_len(input int unsigned pos,
                                          input logic incl);
    return incl ? pos + 1 : pos;
  endfunction

endpackage

// File: rtl/eseq_pred_lane.sv
module eseq_pred_lane
  import eseq_pkg::*;
#(
  parameter int MAX_VL = 128,
  parameter int IW     = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MAX_VL-1:0] mask_in,
  input  logic              en_in,
  input  logic              inv_in,
  input  logic [IW-1:0]     idx,
  output logic              live
);

  logic [MAX_VL-1:0] mask_q;
  logic              en_q;
  logic              inv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
      inv_q  <= 1'b0;
    end else if (load) begin
      mask_q <= mask_in;
      en_q   <= en_in;
      inv_q  <= inv_in;
    end
  end

  assign live = lane_live(mask_q[idx], en_q, inv_q);

endmodule

// File: rtl/eseq_step.sv
module eseq_step #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [LW-1:0] ld_val,
  input  logic          inc,
  output logic [LW-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + LW'(1);
  end

  p_step_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

endmodule

// File: rtl/eseq_ctrl.sv
module eseq_ctrl
  import eseq_pkg::*;
#(
  parameter int MAX_VL = 128,
  parameter int LW     = $clog2(MAX_VL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] cfg_vl,
  input  mode_t         mode_in,
  input  logic          st_wr,
  input  logic          vf_step,
  input  logic [LW-1:0] src_q,
  input  logic [LW-1:0] dst_q,
  input  logic          src_live,
  input  logic          dst_live,
  input  logic          el_ready,
  input  logic          el_fail,
  output logic          busy,
  output logic          el_valid,
  output logic          done,
  output logic          vl_cut,
  output logic [LW-1:0] vl_cur,
  output logic          lane_load,
  output logic          src_inc,
  output logic          dst_inc,
  output logic          step_clr,
  output logic          step_ld
);

  localparam logic [LW-1:0] VL_MAX = LW'(MAX_VL);

  sq_state_t     state_q, state_d;
  mode_t         mode_q, mode_d;
  logic [LW-1:0] vl_q, vl_d;

  logic end_c;
  logic fire;
  logic ff_hit;
  logic wrap_c;

  assign end_c  = (src_q >= vl_q) || (dst_q >= vl_q);
  assign fire   = el_valid && el_ready;
  assign ff_hit = fire && mode_q.ff && el_fail;
  assign wrap_c = (({1'b0, src_q} + (LW+1)'(1)) >= {1'b0, vl_q}) ||
                  (({1'b0, dst_q} + (LW+1)'(1)) >= {1'b0, vl_q});

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    vl_d      = vl_q;
    el_valid  = 1'b0;
    done      = 1'b0;
    vl_cut    = 1'b0;
    lane_load = 1'b0;
    src_inc   = 1'b0;
    dst_inc   = 1'b0;
    step_clr  = 1'b0;
    step_ld   = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          lane_load = 1'b1;
          mode_d    = mode_in;
          vl_d      = (cfg_vl > VL_MAX) ? VL_MAX : cfg_vl;
          state_d   = SQ_RUN;
        end else if (st_wr) begin
          step_ld = 1'b1;
        end else if (vf_step) begin
          if (wrap_c) step_clr = 1'b1;
          else begin
            src_inc = 1'b1;
            dst_inc = 1'b1;
          end
        end
      end
      default: begin
        if (end_c) begin
          done     = 1'b1;
          step_clr = 1'b1;
          state_d  = SQ_IDLE;
        end else if (src_live && dst_live) begin
          el_valid = 1'b1;
          if (fire) begin
            if (ff_hit) begin
              step_clr = 1'b1;
              vl_cut   = 1'b1;
              vl_d     = LW'(cut_len(int'(dst_q), mode_q.incl));
              done     = 1'b1;
              state_d  = SQ_IDLE;
            end else if (mode_q.vf) begin
              done    = 1'b1;
              state_d = SQ_IDLE;
            end else begin
              src_inc = 1'b1;
              dst_inc = 1'b1;
            end
          end
        end else begin
          src_inc = !src_live;
          dst_inc = !dst_live;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      mode_q  <= '0;
      vl_q    <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      vl_q    <= vl_d;
    end
  end

  assign busy   = (state_q == SQ_RUN);
  assign vl_cur = vl_q;

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_vl_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (vl_q <= VL_MAX));

endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
  import eseq_pkg::*;
#(
  parameter int MAX_VL = 128,
  parameter int IW     = $clog2(MAX_VL),
  parameter int LW     = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LW-1:0]     cfg_vl,
  input  logic [MAX_VL-1:0] cfg_src_mask,
  input  logic [MAX_VL-1:0] cfg_dst_mask,
  input  logic              cfg_src_en,
  input  logic              cfg_dst_en,
  input  logic              cfg_src_inv,
  input  logic              cfg_dst_inv,
  input  logic              cfg_vf,
  input  logic              cfg_ff,
  input  logic              cfg_ff_incl,
  input  logic              st_wr,
  input  logic [LW-1:0]     st_src,
  input  logic [LW-1:0]     st_dst,
  input  logic              vf_step,
  output logic              el_valid,
  input  logic              el_ready,
  output logic [IW-1:0]     el_src,
  output logic [IW-1:0]     el_dst,
  input  logic              el_fail,
  output logic              busy,
  output logic              done,
  output logic [LW-1:0]     src_step,
  output logic [LW-1:0]     dst_step,
  output logic [LW-1:0]     vl_cur,
  output logic              vl_cut
);

  // Lane 0 is the source side, lane 1 the destination side.
  logic [1:0]    live_v;
  logic [1:0]    inc_v;
  logic [LW-1:0] step_v [2];
  logic          lane_load;
  logic          step_clr;
  logic          step_ld;
  logic          src_inc;
  logic          dst_inc;
  mode_t         mode_in;

  assign inc_v   = {dst_inc, src_inc};
  assign mode_in = '{vf: cfg_vf, ff: cfg_ff, incl: cfg_ff_incl};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    eseq_pred_lane #(.MAX_VL(MAX_VL), .IW(IW)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (lane_load),
      .mask_in((g == 0) ? cfg_src_mask : cfg_dst_mask),
      .en_in  ((g == 0) ? cfg_src_en : cfg_dst_en),
      .inv_in ((g == 0) ? cfg_src_inv : cfg_dst_inv),
      .idx    (step_v[g][IW-1:0]),
      .live   (live_v[g])
    );

    eseq_step #(.LW(LW)) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (step_clr),
      .ld    (step_ld),
      .ld_val((g == 0) ? st_src : st_dst),
      .inc   (inc_v[g]),
      .q     (step_v[g])
    );
  end

  eseq_ctrl #(.MAX_VL(MAX_VL), .LW(LW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_vl   (cfg_vl),
    .mode_in  (mode_in),
    .st_wr    (st_wr),
    .vf_step  (vf_step),
    .src_q    (step_v[0]),
    .dst_q    (step_v[1]),
    .src_live (live_v[0]),
    .dst_live (live_v[1]),
    .el_ready (el_ready),
    .el_fail  (el_fail),
    .busy     (busy),
    .el_valid (el_valid),
    .done     (done),
    .vl_cut   (vl_cut),
    .vl_cur   (vl_cur),
    .lane_load(lane_load),
    .src_inc  (src_inc),
    .dst_inc  (dst_inc),
    .step_clr (step_clr),
    .step_ld  (step_ld)
  );

  assign el_src   = step_v[0][IW-1:0];
  assign el_dst   = step_v[1][IW-1:0];
  assign src_step = step_v[0];
  assign dst_step = step_v[1];

  p_issue_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid |-> (live_v[0] && live_v[1]));

  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid |-> ((src_step < vl_cur) && (dst_step < vl_cur)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (el_valid && !el_ready) |=> (el_valid && $stable(el_src) && $stable(el_dst)));

  p_end_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !el_valid) |=> ((src_step == '0) && (dst_step == '0)));

  p_cut_shrink_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vl_cut |=> (vl_cur <= $past(vl_cur)));

endmodule

// File: tb/sim_elem_loop_seq.sv
module sim_elem_loop_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_VL = 128;
  localparam int IW = 7;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LW-1:0] cfg_vl = '0;
  logic [MAX_VL-1:0] cfg_src_mask = '0, cfg_dst_mask = '0;
  logic cfg_src_en = 0, cfg_dst_en = 0, cfg_src_inv = 0, cfg_dst_inv = 0;
  logic cfg_vf = 0, cfg_ff = 0, cfg_ff_incl = 0;
  logic st_wr = 0;
  logic [LW-1:0] st_src = '0, st_dst = '0;
  logic vf_step = 0;
  logic el_valid;
  logic el_ready = 0;
  logic [IW-1:0] el_src, el_dst;
  logic el_fail = 0;
  logic busy, done, vl_cut;
  logic [LW-1:0] src_step, dst_step, vl_cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  elem_loop_seq u0 (.*);

  int n_vec = 0;
  int n_bad = 0;
  int ex_s[256], ex_d[256];
  int ex_n, ex_vl;
  int got_s[256], got_d[256];
  int got_n;

  task automatic chk(string req, string what, int act, int expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Reference walk of both counters, phrased from the requirements.
  task automatic model(int vl, logic [127:0] sm, logic [127:0] dm,
                       bit sen, bit den, bit sinv, bit dinv,
                       int s0, int d0, bit ff, bit incl, int fail_ord);
    int lim = (vl > MAX_VL) ? MAX_VL : vl;
    int s = s0;
    int d = d0;
    ex_n = 0;
    ex_vl = lim;
    while (s < lim && d < lim) begin
      bit ok_s = sen ? (sm[s] != sinv) : 1'b1;
      bit ok_d = den ? (dm[d] != dinv) : 1'b1;
      if (ok_s && ok_d) begin
        ex_s[ex_n] = s;
        ex_d[ex_n] = d;
        ex_n++;
        if (ff && (ex_n - 1) == fail_ord) begin
          ex_vl = incl ? d + 1 : d;
          break;
        end
        s++;
        d++;
      end else begin
        if (!ok_s) s++;
        if (!ok_d) d++;
      end
    end
  endtask

  task automatic set_cfg(int vl, logic [127:0] sm, logic [127:0] dm,
                         bit sen, bit den, bit sinv, bit dinv,
                         bit vf, bit ff, bit incl);
    cfg_vl = LW'(vl);
    cfg_src_mask = sm;
    cfg_dst_mask = dm;
    cfg_src_en = sen;
    cfg_dst_en = den;
    cfg_src_inv = sinv;
    cfg_dst_inv = dinv;
    cfg_vf = vf;
    cfg_ff = ff;
    cfg_ff_incl = incl;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic load_steps(int s, int d);
    st_src = LW'(s);
    st_dst = LW'(d);
    st_wr = 1'b1;
    @(negedge clk);
    st_wr = 1'b0;
  endtask

  task automatic do_vf_step();
    vf_step = 1'b1;
    @(negedge clk);
    vf_step = 1'b0;
  endtask

  task automatic run_case(int vl, logic [127:0] sm, logic [127:0] dm,
                          bit sen, bit den, bit sinv, bit dinv,
                          bit ff, bit incl, int fail_ord, int pct);
    bit fin = 0;
    model(vl, sm, dm, sen, den, sinv, dinv, int'(src_step), int'(dst_step),
          ff, incl, fail_ord);
    set_cfg(vl, sm, dm, sen, den, sinv, dinv, 1'b0, ff, incl);
    pulse_start();
    got_n = 0;
    for (int cyc = 0; cyc < 1000 && !fin; cyc++) begin
      el_ready = (($urandom % 100) < pct);
      el_fail = (got_n == fail_ord);
      #1;
      if (el_valid && el_ready) begin
        if (got_n < ex_n) begin
          chk("R3", "src index", int'(el_src), ex_s[got_n]);
          chk("R3", "dst index", int'(el_dst), ex_d[got_n]);
        end
        got_s[got_n] = int'(el_src);
        got_d[got_n] = int'(el_dst);
        got_n++;
      end
      fin = done;
      @(negedge clk);
    end
    el_ready = 1'b0;
    el_fail = 1'b0;
    chk("R2", "instruction finished", int'(fin), 1);
    chk("R5", "pairs issued", got_n, ex_n);
    chk("R8", "vl after loop", int'(vl_cur), ex_vl);
    chk("R5", "src step cleared", int'(src_step), 0);
    chk("R5", "dst step cleared", int'(dst_step), 0);
    chk("R2", "busy low after done", int'(busy), 0);
  endtask

  task automatic vf_once(int es, int ed);
    bit fin = 0;
    int n = 0;
    pulse_start();
    for (int cyc = 0; cyc < 300 && !fin; cyc++) begin
      el_ready = 1'b1;
      #1;
      if (el_valid) begin
        chk("R9", "vf src index", int'(el_src), es);
        chk("R9", "vf dst index", int'(el_dst), ed);
        n++;
      end
      fin = done;
      @(negedge clk);
    end
    el_ready = 1'b0;
    chk("R9", "vf one pair", n, 1);
    chk("R9", "vf src held", int'(src_step), es);
    chk("R9", "vf dst held", int'(dst_step), ed);
    chk("R2", "vf idle after", int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "el_valid", int'(el_valid), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "src step", int'(src_step), 0);
    chk("R1", "dst step", int'(dst_step), 0);
    chk("R1", "vl_cur", int'(vl_cur), 0);

    // R10 scalar identity
    run_case(1, '0, '0, 0, 0, 0, 0, 0, 0, -1, 100);
    chk("R10", "one pair", got_n, 1);
    chk("R10", "pair src", got_s[0], 0);
    chk("R10", "pair dst", got_d[0], 0);

    // R4 complementary masks interleave
    run_case(4, 128'h5, 128'h5, 1, 1, 0, 1, 0, 0, -1, 100);
    chk("R4", "pair count", got_n, 2);
    chk("R4", "pair0 src", got_s[0], 0);
    chk("R4", "pair0 dst", got_d[0], 1);
    chk("R4", "pair1 src", got_s[1], 2);
    chk("R4", "pair1 dst", got_d[1], 3);

    // R3 compress: source mask only
    run_case(8, 128'hB2, '0, 1, 0, 0, 0, 0, 0, -1, 60);
    chk("R3", "compress count", got_n, 4);
    chk("R3", "compress dst", got_d[3], 3);
    chk("R3", "compress src", got_s[3], 7);
    // R3 expand: destination mask only
    run_case(8, '0, 128'hB2, 0, 1, 0, 0, 0, 0, -1, 60);
    chk("R3", "expand src", got_s[2], 2);
    chk("R3", "expand dst", got_d[2], 5);

    // R5 zero length
    run_case(0, '0, '0, 0, 0, 0, 0, 0, 0, -1, 100);
    // R11 full and clamped length
    run_case(64, '0, '0, 0, 0, 0, 0, 0, 0, -1, 100);
    run_case(200, '0, '0, 0, 0, 0, 0, 0, 0, -1, 100);
    chk("R11", "clamped pair count", got_n, 128);

    // R7 resume from preloaded steps
    load_steps(3, 5);
    chk("R7", "src loaded", int'(src_step), 3);
    chk("R7", "dst loaded", int'(dst_step), 5);
    run_case(10, 128'h3FF, 128'h155, 1, 1, 0, 0, 0, 0, -1, 80);
    chk("R7", "resume first src", got_s[0], 3);

    // R8 fail-first exclude, include, disabled
    run_case(16, '0, '0, 0, 0, 0, 0, 1, 0, 5, 100);
    chk("R8", "exclude vl", int'(vl_cur), 5);
    run_case(16, '0, '0, 0, 0, 0, 0, 1, 1, 5, 100);
    chk("R8", "include vl", int'(vl_cur), 6);
    run_case(16, '0, '0, 0, 0, 0, 0, 0, 1, 5, 100);
    chk("R8", "fail ignored", got_n, 16);

    // R2/R7 start and state write ignored while busy; R6 hold
    set_cfg(8, '0, '0, 0, 0, 0, 0, 0, 0, 0);
    pulse_start();
    @(negedge clk);
    load_steps(5, 5);
    set_cfg(3, '0, '0, 0, 0, 0, 0, 0, 0, 0);
    pulse_start();
    chk("R7", "write ignored src", int'(src_step), 0);
    chk("R7", "write ignored dst", int'(dst_step), 0);
    chk("R2", "start ignored vl", int'(vl_cur), 8);
    chk("R6", "valid held", int'(el_valid), 1);
    chk("R2", "busy held", int'(busy), 1);
    el_ready = 1'b1;
    for (int cyc = 0; cyc < 100 && busy; cyc++) @(negedge clk);
    el_ready = 1'b0;
    chk("R2", "busy released", int'(busy), 0);

    // R9 vertical-first
    set_cfg(4, '0, '0, 0, 0, 0, 0, 1, 0, 0);
    vf_once(0, 0);
    do_vf_step();
    chk("R9", "step src", int'(src_step), 1);
    chk("R9", "step dst", int'(dst_step), 1);
    vf_once(1, 1);
    do_vf_step();
    do_vf_step();
    chk("R9", "step to 3", int'(src_step), 3);
    do_vf_step();
    chk("R9", "wrap src", int'(src_step), 0);
    chk("R9", "wrap dst", int'(dst_step), 0);
    set_cfg(4, 128'h6, '0, 1, 0, 0, 0, 1, 0, 0);
    vf_once(1, 0);
    load_steps(0, 0);

    // Random mix
    for (int k = 0; k < 60; k++) begin
      int vl = (k % 3 == 0) ? int'($urandom % 131) : int'($urandom % 24);
      logic [127:0] sm = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] dm = {$urandom, $urandom, $urandom, $urandom};
      bit ff = ($urandom % 3) == 0;
      int fo = (($urandom % 2) == 0) ? int'($urandom % 12) : -1;
      if (($urandom % 4) == 0) load_steps(int'($urandom % 6), int'($urandom % 6));
      run_case(vl, sm, dm, 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), ff, 1'($urandom), fo, 30 + int'($urandom % 71));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule